// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full `2*WIDTH`-bit signed product. It scans the multiplier two bits per clock. Each step looks at a three-bit window made of the next two multiplier bits and the bit just below them. A zero is assumed below the least significant bit, and neighbouring windows share one bit. Each window is recoded into a digit of 0, ±1 or ±2 times the multiplicand. The scaled multiple is sign-extended to the full product width, weighted by four per step, and added to an accumulator through a single shared adder. A negative digit is applied as a subtraction.

A client pulses `start_i` with both operands valid. Exactly `WIDTH/2` cycles later `done_o` is high for one cycle, and `product_o` carries the result. The result stays on `product_o` until the next accepted start. Because the multiplier is recoded, only half as many partial products are summed as in plain shift-and-add, so the latency is half the operand width.

Top module: `radix4_booth_mul`

## Requirements
- R1: While `rst_ni` is low, `done_o` is 0 and `product_o` is all zeros.
- R2: When `start_i` is sampled high while no multiplication is running, both operands are captured. `done_o` rises exactly `WIDTH/2` clock edges after that capturing edge, and `product_o` then equals the signed product of the captured operands.
- R3: `done_o` is high for exactly one cycle per accepted start.
- R4: When no multiplication is running and `start_i` is low, `product_o` keeps its value from one cycle to the next. After reset it holds zero, and after a completion it holds the last product.
- R5: `start_i` and operand changes during a running multiplication are ignored. The running result and its completion time are unaffected.
- R6: The results are exact at the range extremes. This includes the most negative value times itself (result `2^(2*WIDTH-2)`), the most negative value times the most positive value, and either operand zero.
- R7: Each window is read as {higher bit, middle bit, lower bit}. Windows 000 and 111 add nothing. Windows 001 and 010 add the multiplicand. Window 011 adds twice the multiplicand. Window 100 subtracts twice the multiplicand. Windows 101 and 110 subtract the multiplicand. Step i adds its digit weighted by 4^i.
- R8: The latency is the same for every operand pair, including zero operands.
- R9: A start sampled in the same cycle as `done_o` is accepted, so back-to-back products complete every `WIDTH/2 + 1` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication when idle |
| mcand_i | input | WIDTH | Multiplicand, two's complement |
| mplier_i | input | WIDTH | Multiplier, two's complement |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2*WIDTH | Signed product |

## Verification
A wrong recoding or a wrong weighting of one step shows up as a product error on the `done_o` cycle of any operation whose multiplier has that window at that step. This is why exhaustive sweeps of each operand against a fixed partner are used. A corrupted step counter or busy flag moves `done_o` off the expected edge. It also shows as a double pulse, or as a start that is wrongly accepted or refused. Either way it is caught within `WIDTH/2 + 1` cycles of the start. A sign-extension or carry-in fault only shows for negative digits, so the extreme-value operands are exercised directly.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [2:0] {
    DIG_ZERO,
    DIG_POS1,
    DIG_POS2,
    DIG_NEG1,
    DIG_NEG2
  } booth_digit_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0]   win_i,
  output booth_digit_e digit_o
);
  always_comb begin
    unique case (win_i)
      3'b001, 3'b010: digit_o = DIG_POS1;
      3'b011:         digit_o = DIG_POS2;
      3'b100:         digit_o = DIG_NEG2;
      3'b101, 3'b110: digit_o = DIG_NEG1;
      default:        digit_o = DIG_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] mcand_i,
  input  booth_digit_e  digit_i,
  output logic [PW-1:0] addend_o,
  output logic          cin_o
);
  logic [PW-1:0] dbl;
  assign dbl = {mcand_i[PW-2:0], 1'b0};

  // negative digits: one's complement plus carry-in
  always_comb begin
    unique case (digit_i)
      DIG_POS1: begin addend_o = mcand_i;  cin_o = 1'b0; end
      DIG_POS2: begin addend_o = dbl;      cin_o = 1'b0; end
      DIG_NEG1: begin addend_o = ~mcand_i; cin_o = 1'b1; end
      DIG_NEG2: begin addend_o = ~dbl;     cin_o = 1'b1; end
      default:  begin addend_o = '0;       cin_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int unsigned STEPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] step_q;
  logic          busy_q, done_q, last;

  assign last   = (step_q == CW'(STEPS - 1));
  assign load_o = start_i & ~busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q & last;
      if (load_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        step_q <= step_q + CW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/radix4_booth_mul.sv
module radix4_booth_mul
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int unsigned PW    = 2 * WIDTH;
  localparam int unsigned STEPS = WIDTH / 2;

  if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
    $error("WIDTH must be even and at least 4");
  end

  logic          load, busy;
  logic [WIDTH:0] win_q;
  logic [PW-1:0]  mcand_q, acc_q, addend, sum;
  logic           cin;
  booth_digit_e   digit;

  booth_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .busy_o (busy),
    .done_o (done_o)
  );

  booth_recoder rec_i (
    .win_i  (win_q[2:0]),
    .digit_o(digit)
  );

  booth_ppgen #(.PW(PW)) ppg_i (
    .mcand_i (mcand_q),
    .digit_i (digit),
    .addend_o(addend),
    .cin_o   (cin)
  );

  // the single shared adder
  assign sum = acc_q + addend + PW'(cin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      mcand_q <= '0;
      acc_q   <= '0;
    end else if (load) begin
      win_q   <= {mplier_i, 1'b0};
      mcand_q <= {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
      acc_q   <= '0;
    end else if (busy) begin
      win_q   <= {{2{win_q[WIDTH]}}, win_q[WIDTH:2]};
      mcand_q <= {mcand_q[PW-3:0], 2'b00};
      acc_q   <= sum;
    end
  end

  assign product_o = acc_q;
endmodule

// File: rtl/radix4_booth_mul_chk.sv
module radix4_booth_mul_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic               busy_i
);
  localparam int unsigned STEPS = WIDTH / 2;

  int unsigned        lat_q;
  logic [WIDTH-1:0]   a_q, b_q;
  logic [2*WIDTH-1:0] ea, eb, ref_prod;

  assign ea       = {{WIDTH{a_q[WIDTH-1]}}, a_q};
  assign eb       = {{WIDTH{b_q[WIDTH-1]}}, b_q};
  assign ref_prod = ea * eb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (start_i && !busy_i) begin
      lat_q <= 0;
      a_q   <= mcand_i;
      b_q   <= mplier_i;
    end else if (busy_i) begin
      lat_q <= lat_q + 1;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == STEPS);

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> busy_i);

  // R6
  product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> product_o == ref_prod);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !start_i |=> $stable(product_o));
endmodule

bind radix4_booth_mul radix4_booth_mul_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .done_o   (done_o),
  .product_o(product_o),
  .busy_i   (busy)
);

// File: tb/radix4_booth_mul_tb_top.sv
module radix4_booth_mul_tb_top;
  localparam int unsigned W     = 8;
  localparam int unsigned STEPS = W / 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b1;
  logic           start_i = 1'b0;
  logic [W-1:0]   mcand_i = '0;
  logic [W-1:0]   mplier_i = '0;
  logic           done_o;
  logic [2*W-1:0] product_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  string cur_req = "R1";

  always #2 clk_i = ~clk_i;

  radix4_booth_mul #(.WIDTH(W)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .done_o   (done_o),
    .product_o(product_o)
  );

  function automatic logic [2*W-1:0] smul(logic [W-1:0] a, logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return (2*W)'(sa * sb);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) act=%0h exp=%0h t=%0t", req, cur_req, act, exp, $time);
    end
  endtask

  // reference model, advanced on each edge
  bit             m_busy = 0, m_done = 0;
  int             m_cnt  = 0;
  logic [W-1:0]   m_a = '0, m_b = '0;
  logic [2*W-1:0] m_prod = '0;

  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (!m_busy && start_i) begin
        m_busy = 1; m_cnt = STEPS; m_a = mcand_i; m_b = mplier_i;
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_prod = smul(m_a, m_b);
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(done_o == m_done, "R3 done timing R8", 64'(done_o), 64'(m_done));
      if (!m_busy)
        chk(product_o == m_prod, m_done ? "R2 product" : "R4 idle hold",
            64'(product_o), 64'(m_prod));
    end
  end

  task automatic op(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk_i);
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (STEPS) @(negedge clk_i);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(done_o == 1'b0, "R1 done", 64'(done_o), 0);
    chk(product_o == '0, "R1 product", 64'(product_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    cur_req = "R7 window sweep";
    for (int i = 0; i < (1 << W); i++) op(8'h5B, W'(i));
    for (int i = 0; i < (1 << W); i++) op(W'(i), 8'hA6);

    cur_req = "R6 extremes";
    op(8'h80, 8'h80);
    op(8'h80, 8'h7F);
    op(8'h7F, 8'h80);
    op(8'h7F, 8'h7F);
    op(8'h80, 8'h01);
    op(8'hFF, 8'h80);

    cur_req = "R8 zero operands";
    op(8'h00, 8'h93);
    op(8'h6C, 8'h00);

    cur_req = "R5 ignore start while busy";
    @(negedge clk_i);
    start_i = 1'b1; mcand_i = 8'h35; mplier_i = 8'hC9;
    @(negedge clk_i);
    mcand_i = 8'h80; mplier_i = 8'h80;
    @(negedge clk_i);
    start_i = 1'b0; mcand_i = 8'h11; mplier_i = 8'h22;
    repeat (STEPS) @(negedge clk_i);
    repeat (2) @(negedge clk_i);

    cur_req = "R9 back-to-back";
    start_i = 1'b1;
    for (int k = 0; k < 20; k++) begin
      mcand_i = W'($urandom); mplier_i = W'($urandom);
      repeat (STEPS + 1) @(negedge clk_i);
    end
    start_i = 1'b0;
    repeat (STEPS + 2) @(negedge clk_i);

    cur_req = "R2 random";
    for (int k = 0; k < 600; k++) op(W'($urandom), W'($urandom));

    cur_req = "R4 idle";
    repeat (10) @(negedge clk_i);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (%s) act=%0d exp=0", cur_req, cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule